// File: doc/BRIEF.md
# Variable-Rate Slot Valid Gate

This block decides, once per audio frame and separately for each output slot, whether the controller places a real sample in that slot. In fixed-rate operation every frame carries one sample per slot, so the sample rate equals the frame rate. In on-demand operation the codec returns a request flag per slot in each frame. A frame whose request is absent goes out with the slot tagged invalid and filled with zeros. Thinning the frames this way gives rates below the frame rate. For example, dropping 39 of every 480 frames at a 48 kHz frame rate gives 44.1 kHz.

On the transmit side the block pops a first-word-fall-through transmit FIFO only when a sample is actually sent. When a request finds the FIFO empty, the slot is sent tagged valid with zero data and an underrun flag is raised for that frame. On the receive side the codec mixes empty frames among valid ones. The block forwards a slot's sample into the receive path only when the codec tagged that slot valid in that frame.

Top module: `vrate_slot_gate`

## Requirements
- R1: While reset is asserted and after its release, before any frame strobe, `slot_valid`, `slot_data`, `underrun` and `rx_push` are all zero.
- R2: With `ondemand_en` = 0, every frame strobe marks every slot valid (bit s of `slot_valid` = 1), whatever the value of `slot_req`.
- R3: With `ondemand_en` = 1, the value of bit s of `slot_req` in the frame-strobe cycle sets bit s of `slot_valid`, `slot_data` and `underrun` for the frame that follows. These outputs are registered and change on the clock edge that samples the strobe.
- R4: A slot with no request (`ondemand_en` = 1, `slot_req` bit 0) is tagged invalid and its data field is zero. Its `tx_pop` bit stays 0.
- R5: A slot that is needed while its `tx_avail` bit is 0 is tagged valid with zero data. Its `underrun` bit is 1 for that frame and its `tx_pop` bit stays 0.
- R6: A `tx_pop` bit is 1 only during a frame-strobe cycle in which that slot is needed and its `tx_avail` bit is 1. In that case the slot's data field for the next frame equals the `tx_data` word presented in the strobe cycle. Slot s uses bits [s*SAMPLE_W +: SAMPLE_W] of the data buses.
- R7: The slots are gated independently. Each slot's outputs depend only on that slot's request, availability and data bits.
- R8: An `rx_strobe` with bit s of `rx_tag` = 1 makes bit s of `rx_push` 1 for exactly the next cycle, with `rx_word` slot s carrying the strobed `rx_data` field. A slot with a tag of 0 produces no push and leaves its `rx_word` field unchanged.
- R9: With `ondemand_en` = 1 over 480 frames, of which 39 carry no request, each slot pops exactly 441 samples.
- R10: `slot_valid`, `slot_data` and `underrun` hold their values between frame strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| frame_strobe | input | 1 | One-cycle pulse at each outgoing frame boundary |
| ondemand_en | input | 1 | 1 = follow codec slot requests, 0 = sample every frame |
| slot_req | input | NUM_SLOTS | Codec request flag per slot for the next frame |
| tx_avail | input | NUM_SLOTS | Transmit FIFO non-empty per slot |
| tx_data | input | NUM_SLOTS*SAMPLE_W | Transmit FIFO head word per slot |
| tx_pop | output | NUM_SLOTS | Transmit FIFO pop per slot, combinational, during the strobe |
| slot_valid | output | NUM_SLOTS | Valid tag per slot for the current frame |
| slot_data | output | NUM_SLOTS*SAMPLE_W | Sample per slot for the current frame |
| underrun | output | NUM_SLOTS | Requested but FIFO was empty, this frame |
| rx_strobe | input | 1 | One-cycle pulse when a received frame is complete |
| rx_tag | input | NUM_SLOTS | Codec valid tag per received slot |
| rx_data | input | NUM_SLOTS*SAMPLE_W | Received sample per slot |
| rx_push | output | NUM_SLOTS | Receive FIFO push per slot, one cycle |
| rx_word | output | NUM_SLOTS*SAMPLE_W | Captured received sample per slot |

## Verification
`tx_pop` is combinational and is due in the strobe cycle itself. The bench reads it shortly after driving the strobe, before the clock edge. The frame outputs `slot_valid`, `slot_data` and `underrun` take one register stage and are due after the edge that samples the strobe. The monitor compares them at the following falling edge against the scoreboard entry queued for that frame. It compares them again one idle cycle later to confirm they hold. `rx_push` and `rx_word` also take one register stage: they are checked at the falling edge after the receive strobe, and the push is checked to have dropped one cycle later.

// File: rtl/vrsg_pkg.sv
package vrsg_pkg;
  // A slot needs a sample either in fixed-rate operation or when requested.
  function automatic logic slot_needed(input logic ondemand, input logic req);
    return (!ondemand) | req;
  endfunction
endpackage

// File: rtl/vrsg_tx_lane.sv
module vrsg_tx_lane #(
  parameter int SAMPLE_W = 20
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                frame_strobe,
  input  logic                ondemand_en,
  input  logic                req,
  input  logic                avail,
  input  logic [SAMPLE_W-1:0] fifo_word,
  output logic                pop,
  output logic                valid_q,
  output logic [SAMPLE_W-1:0] data_q,
  output logic                urun_q
);
  import vrsg_pkg::*;

  logic                need;
  logic                valid_d;
  logic                urun_d;
  logic [SAMPLE_W-1:0] data_d;

  always_comb begin
    need    = slot_needed(ondemand_en, req);
    pop     = frame_strobe & need & avail;
    valid_d = need;
    urun_d  = need & ~avail;
    data_d  = (need & avail) ? fifo_word : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      urun_q  <= 1'b0;
      data_q  <= '0;
    end else if (frame_strobe) begin
      valid_q <= valid_d;
      urun_q  <= urun_d;
      data_q  <= data_d;
    end
  end

  a_r6_pop_needs_avail: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (avail && frame_strobe));
  a_r6_pop_word_sent: assert property (@(posedge clk) disable iff (!rst_n)
    pop |=> (valid_q && data_q == $past(fifo_word)));
  a_r5_underrun_is_valid: assert property (@(posedge clk) disable iff (!rst_n)
    urun_q |-> (valid_q && data_q == '0));
  a_r4_invalid_is_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_q |-> (data_q == '0 && !urun_q));
  a_r10_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_strobe |=> ($stable(valid_q) && $stable(data_q) && $stable(urun_q)));
endmodule

// File: rtl/vrsg_rx_lane.sv
module vrsg_rx_lane #(
  parameter int SAMPLE_W = 20
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rx_strobe,
  input  logic                tag,
  input  logic [SAMPLE_W-1:0] sample,
  output logic                push_q,
  output logic [SAMPLE_W-1:0] word_q
);
  logic take;

  always_comb take = rx_strobe & tag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) push_q <= 1'b0;
    else        push_q <= take;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    word_q <= '0;
    else if (take) word_q <= sample;
  end

  a_r8_push_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    push_q |=> (!push_q || $past(rx_strobe)));
  a_r8_untagged_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_strobe && tag) |=> (!push_q && $stable(word_q)));
endmodule

// File: rtl/vrate_slot_gate.sv
module vrate_slot_gate #(
  parameter int NUM_SLOTS = 2,
  parameter int SAMPLE_W  = 20,
  localparam int BUS_W    = NUM_SLOTS * SAMPLE_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 frame_strobe,
  input  logic                 ondemand_en,
  input  logic [NUM_SLOTS-1:0] slot_req,
  input  logic [NUM_SLOTS-1:0] tx_avail,
  input  logic [BUS_W-1:0]     tx_data,
  output logic [NUM_SLOTS-1:0] tx_pop,
  output logic [NUM_SLOTS-1:0] slot_valid,
  output logic [BUS_W-1:0]     slot_data,
  output logic [NUM_SLOTS-1:0] underrun,
  input  logic                 rx_strobe,
  input  logic [NUM_SLOTS-1:0] rx_tag,
  input  logic [BUS_W-1:0]     rx_data,
  output logic [NUM_SLOTS-1:0] rx_push,
  output logic [BUS_W-1:0]     rx_word
);
  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    vrsg_tx_lane #(.SAMPLE_W(SAMPLE_W)) u_tx (
      .clk          (clk),
      .rst_n        (rst_n),
      .frame_strobe (frame_strobe),
      .ondemand_en  (ondemand_en),
      .req          (slot_req[s]),
      .avail        (tx_avail[s]),
      .fifo_word    (tx_data[s*SAMPLE_W +: SAMPLE_W]),
      .pop          (tx_pop[s]),
      .valid_q      (slot_valid[s]),
      .data_q       (slot_data[s*SAMPLE_W +: SAMPLE_W]),
      .urun_q       (underrun[s])
    );

    vrsg_rx_lane #(.SAMPLE_W(SAMPLE_W)) u_rx (
      .clk       (clk),
      .rst_n     (rst_n),
      .rx_strobe (rx_strobe),
      .tag       (rx_tag[s]),
      .sample    (rx_data[s*SAMPLE_W +: SAMPLE_W]),
      .push_q    (rx_push[s]),
      .word_q    (rx_word[s*SAMPLE_W +: SAMPLE_W])
    );
  end

  // R2: fixed-rate operation tags every slot on the frame after a strobe.
  a_r2_fixed_rate_all_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_strobe && !ondemand_en) |=> (slot_valid == '1));
  // R3: an on-demand frame follows the request bits.
  a_r3_valid_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_strobe && ondemand_en) |=> (slot_valid == $past(slot_req)));
  // R4: a pop happens only on a strobe.
  a_r4_pop_only_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_strobe |-> (tx_pop == '0));
endmodule

// File: tb/vrate_slot_gate_test.sv
`timescale 1ns/1ps
module vrate_slot_gate_test;
  localparam int S  = 2;
  localparam int SW = 20;
  localparam int BW = S * SW;

  typedef struct packed {
    logic [S-1:0]  v;
    logic [S-1:0]  u;
    logic [BW-1:0] d;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          frame_strobe = 1'b0;
  logic          ondemand_en = 1'b0;
  logic [S-1:0]  slot_req = '0;
  logic [S-1:0]  tx_avail = '0;
  logic [BW-1:0] tx_data = '0;
  logic [S-1:0]  tx_pop;
  logic [S-1:0]  slot_valid;
  logic [BW-1:0] slot_data;
  logic [S-1:0]  underrun;
  logic          rx_strobe = 1'b0;
  logic [S-1:0]  rx_tag = '0;
  logic [BW-1:0] rx_data = '0;
  logic [S-1:0]  rx_push;
  logic [BW-1:0] rx_word;

  int   n_vec = 0;
  int   n_bad = 0;
  exp_t sb_q[$];
  exp_t last_exp;
  logic chk_due = 1'b0;
  int   pops [S];
  logic [BW-1:0] rx_model = '0;

  vrate_slot_gate #(.NUM_SLOTS(S), .SAMPLE_W(SW)) uut (.*);

  always #5 clk = ~clk;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: compare the registered frame outputs one edge after the strobe.
  always @(posedge clk) chk_due <= frame_strobe;
  always @(negedge clk) begin
    if (chk_due && sb_q.size() > 0) begin
      last_exp = sb_q.pop_front();
      check("R3 slot_valid", 64'(slot_valid), 64'(last_exp.v));
      check("R4/R6 slot_data", 64'(slot_data), 64'(last_exp.d));
      check("R5 underrun", 64'(underrun), 64'(last_exp.u));
    end
  end

  task automatic tx_frame(input logic od, input logic [S-1:0] req,
                          input logic [S-1:0] av, input logic [BW-1:0] dat,
                          input string tag);
    exp_t e;
    logic [S-1:0] epop;
    @(negedge clk);
    ondemand_en = od; slot_req = req; tx_avail = av; tx_data = dat;
    frame_strobe = 1'b1;
    for (int s = 0; s < S; s++) begin
      logic need;
      need = !od || req[s];
      epop[s]  = need && av[s];
      e.v[s]   = need;
      e.u[s]   = need && !av[s];
      e.d[s*SW +: SW] = (need && av[s]) ? dat[s*SW +: SW] : '0;
    end
    #1;
    check({tag, " R6 tx_pop"}, 64'(tx_pop), 64'(epop));
    for (int s = 0; s < S; s++) pops[s] += int'(tx_pop[s]);
    sb_q.push_back(e);
    @(negedge clk);
    frame_strobe = 1'b0;
    slot_req = ~req; tx_avail = ~av; tx_data = ~dat;
    #1;
    check({tag, " R4 no pop off strobe"}, 64'(tx_pop), 64'd0);
    @(negedge clk);
    check({tag, " R10 hold valid"}, 64'(slot_valid), 64'(e.v));
    check({tag, " R10 hold data"}, 64'(slot_data), 64'(e.d));
  endtask

  task automatic rx_frame(input logic [S-1:0] tg, input logic [BW-1:0] dat);
    @(negedge clk);
    rx_strobe = 1'b1; rx_tag = tg; rx_data = dat;
    for (int s = 0; s < S; s++)
      if (tg[s]) rx_model[s*SW +: SW] = dat[s*SW +: SW];
    @(negedge clk);
    rx_strobe = 1'b0; rx_tag = ~tg; rx_data = ~dat;
    check("R8 rx_push", 64'(rx_push), 64'(tg));
    check("R8 rx_word", 64'(rx_word), 64'(rx_model));
    @(negedge clk);
    check("R8 push one cycle", 64'(rx_push), 64'd0);
    check("R8 word kept", 64'(rx_word), 64'(rx_model));
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    for (int s = 0; s < S; s++) pops[s] = 0;
    repeat (3) @(negedge clk);
    check("R1 valid in reset", 64'(slot_valid), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 valid", 64'(slot_valid), 64'd0);
    check("R1 data", 64'(slot_data), 64'd0);
    check("R1 underrun", 64'(underrun), 64'd0);
    check("R1 rx_push", 64'(rx_push), 64'd0);

    // R2: fixed rate ignores requests
    tx_frame(1'b0, 2'b00, 2'b11, {20'hAAAA1, 20'h55552}, "R2");
    tx_frame(1'b0, 2'b01, 2'b11, {20'h12345, 20'h6789A}, "R2");
    // R2 with one FIFO empty -> R5
    tx_frame(1'b0, 2'b00, 2'b01, {20'hFFFFF, 20'h00777}, "R2/R5");
    // R3/R7: independent per-slot requests
    tx_frame(1'b1, 2'b01, 2'b11, {20'hBEEF0, 20'h0CAFE}, "R3/R7");
    tx_frame(1'b1, 2'b10, 2'b11, {20'h13579, 20'h2468A}, "R3/R7");
    // R4: no request at all
    tx_frame(1'b1, 2'b00, 2'b11, {20'hDEAD1, 20'hDEAD2}, "R4");
    // R5: requested while empty
    tx_frame(1'b1, 2'b11, 2'b00, {20'h11111, 20'h22222}, "R5");
    tx_frame(1'b1, 2'b11, 2'b10, {20'h33333, 20'h44444}, "R5/R7");
    // R8: receive gating
    rx_frame(2'b11, {20'hA0A0A, 20'hB0B0B});
    rx_frame(2'b01, {20'hC0C0C, 20'hD0D0D});
    rx_frame(2'b00, {20'hE0E0E, 20'hF0F0F});
    rx_frame(2'b10, {20'h01234, 20'h56789});

    // R9: 480 frames with 39 unrequested frames spread evenly
    for (int s = 0; s < S; s++) pops[s] = 0;
    for (int f = 0; f < 480; f++) begin
      logic skip;
      skip = ((f + 1) * 39 / 480) != (f * 39 / 480);
      tx_frame(1'b1, skip ? 2'b00 : 2'b11, 2'b11,
               {SW'(f * 3 + 1), SW'(f * 5 + 2)}, "R9");
    end
    for (int s = 0; s < S; s++) check("R9 pops per 480 frames", 64'(pops[s]), 64'd441);

    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule